// File: doc/BRIEF.md
# Packed-Lane Linear Array Matrix Accumulator

This block is a row of processing elements (PEs) that updates a tile of C in place as C = A×B ± C. Each PE keeps one 64-bit A word in a register and one row of the C tile in a private RAM of `DEPTH` words. Rows of B stream in one element per column. Every element is broadcast to all PEs at once, and each PE does a read-modify-write on the C word at that column. Every 64-bit word is split into one 64-bit lane, two 32-bit lanes or four 16-bit lanes, chosen by `lane_mode`. A PE therefore holds one, two or four rows of C at once. The lowest lane carries the first of those rows.

For a multiply pass, the block clears every RAM word before B is accepted. For addition or subtraction, the caller preloads the C tile and streams an identity matrix as B. The A operand then selects its own column, and the lane result is added to or subtracted from C. Once the last write-back of the last B row has landed, `done` pulses for one cycle. The tile then drains one word per handshake, ordered by PE first and column second.

The controller has five states. IDLE accepts preloads and `start`. CLEAR zeroes the RAMs. STREAM accepts B. FLUSH waits for in-flight write-backs. DRAIN sends C out. The transitions are:
- IDLE→CLEAR on `start` with the multiply operation; IDLE→STREAM on `start` with add or subtract.
- CLEAR→STREAM once the last RAM address has been zeroed.
- STREAM→FLUSH on the final B element, or at once when `k_rows` is zero.
- FLUSH→DRAIN when the pipeline is empty, which is also the `done` cycle.
- DRAIN→IDLE on the handshake of the last word.

Top module: `pla_array`

## Requirements
- R1: While reset is held and in the first cycle after it, `b_ready`, `done` and `dr_valid` are low.
- R2: With `op_sel`=0 (multiply), every accumulation word starts the pass at zero, whatever was preloaded.
- R3: With `lane_mode`=0, each update is c = c + a×b over the full 64 bits, wrapping modulo 2^64.
- R4: With `lane_mode`=1, bits [31:0] and [63:32] are separate lanes. The B element is bits [31:0] of `b_elem`, replicated into both lanes. Bits [63:32] of `b_elem` are ignored.
- R5: With `lane_mode`=2, the word holds four 16-bit lanes, lane i at bits [16i+15:16i]. The B element is bits [15:0] of `b_elem`, replicated into all four lanes.
- R6: Each lane product and sum wraps within the lane width, and no carry or borrow crosses a lane boundary.
- R7: With `op_sel`=1 (add), the preloaded C words are kept and each update is c = c + a×b.
- R8: With `op_sel`=2 (subtract), the preloaded C words are kept and each update is c = c − a×b.
- R9: Consecutive B elements aimed at the same column, as when `n_cols`=1, accumulate correctly. `b_ready` is held low until the earlier write-back to that column has landed.
- R10: `done` is high for exactly one cycle, after the last write-back and in the cycle before the first valid drain word. This holds also for `k_rows`=0.
- R11: The drain emits PE 0 columns 0..`n_cols`−1, then PE 1 and so on. Each word is held stable while `dr_ready` is low.
- R12: Preload writes are ignored outside IDLE.
- R13: `b_ready` is low outside STREAM, so B elements presented then are not consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (taken in IDLE only) |
| lane_mode | input | 2 | 0: 1×64, 1: 2×32, 2: 4×16 lanes (3 acts as 0) |
| op_sel | input | 2 | 0: multiply, 1: add, 2: subtract (3 acts as add) |
| k_rows | input | KW | Number of B rows in the pass |
| n_cols | input | CW | Columns used, 1..DEPTH |
| ld_valid | input | 1 | Preload strobe |
| ld_to_c | input | 1 | 1: write C RAM word, 0: write A register |
| ld_pe | input | PEW | Target PE |
| ld_addr | input | AW | C column for a RAM preload |
| ld_data | input | 64 | Preload data |
| b_valid | input | 1 | B element valid |
| b_elem | input | 64 | B element (low lane bits used) |
| b_ready | output | 1 | B element accepted this cycle when valid |
| done | output | 1 | One-cycle pulse after the last write-back |
| dr_valid | output | 1 | Drain word valid |
| dr_ready | input | 1 | Drain consumer ready |
| dr_data | output | 64 | Drained C word |

## Verification
The multiply path is driven with random A, B and preloaded junk C in each lane width. A wrong clear, lane split or replication source then shows up as a mismatch in a specific lane. Identity-B streams with preloaded C separate add from subtract, and a random-B subtract pass catches a sign error that the identity pattern could hide. A single-column pass stresses the read-modify-write hazard, and a zero-row pass isolates the `done` timing. A final pass drives preloads and B during the drain, together with random `dr_ready` stalls, so that ignored inputs and the drain ordering both appear at the output.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        LM_X1  = 2'd0,
        LM_X2  = 2'd1,
        LM_X4  = 2'd2,
        LM_RSV = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_STREAM,
        S_FLUSH,
        S_DRAIN
    } ctrl_state_e;

    // Copy the low lane of b into every lane of the word.
    function automatic logic [63:0] lane_rep(lane_mode_e m, logic [63:0] b);
        logic [63:0] r;
        unique case (m)
            LM_X4:   r = {4{b[15:0]}};
            LM_X2:   r = {2{b[31:0]}};
            default: r = b;
        endcase
        return r;
    endfunction

    // Lane-wise c +/- a*b with wrap inside each lane.
    function automatic logic [63:0] lane_mac(lane_mode_e m, logic sub,
                                             logic [63:0] a, logic [63:0] b,
                                             logic [63:0] c);
        logic [63:0] r;
        logic [15:0] p16;
        logic [31:0] p32;
        logic [63:0] p64;
        r = '0;
        unique case (m)
            LM_X4: begin
                for (int i = 0; i < 4; i++) begin
                    p16 = a[16*i +: 16] * b[16*i +: 16];
                    r[16*i +: 16] = sub ? (c[16*i +: 16] - p16) : (c[16*i +: 16] + p16);
                end
            end
            LM_X2: begin
                for (int i = 0; i < 2; i++) begin
                    p32 = a[32*i +: 32] * b[32*i +: 32];
                    r[32*i +: 32] = sub ? (c[32*i +: 32] - p32) : (c[32*i +: 32] + p32);
                end
            end
            default: begin
                p64 = a * b;
                r   = sub ? (c - p64) : (c + p64);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
    import pla_pkg::*;
#(
    parameter int NPE   = 4,
    parameter int DEPTH = 512,
    parameter int LAT   = 3,
    parameter int KW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PEW  = $clog2(NPE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode_in,
    input  logic [1:0]       op_in,
    input  logic [KW-1:0]    k_rows,
    input  logic [CW-1:0]    n_cols,
    input  logic             b_valid,
    input  logic [63:0]      b_elem,
    input  logic             dr_ready,
    output logic             b_ready,
    output logic             done,
    output logic             dr_valid,
    output logic [PEW-1:0]   dr_pe,
    output logic [AW-1:0]    rd_addr,
    output logic             clr_en,
    output logic [AW-1:0]    clr_addr,
    output logic             acc_fire,
    output logic             wb_en,
    output logic [AW-1:0]    wb_addr,
    output logic [63:0]      wb_b,
    output logic             ld_ok,
    output lane_mode_e       cfg_mode,
    output logic             cfg_sub
);

    ctrl_state_e st, st_nx;
    op_e            op_q;
    logic [KW-1:0]  k_q, row_cnt;
    logic [CW-1:0]  ncol_q;
    logic [AW-1:0]  col_cnt, clr_cnt, dr_col, ncol_m1;
    logic [PEW-1:0] dr_pe_q;
    logic [LAT-1:0] pv;
    logic [AW-1:0]  pa [LAT];
    logic [63:0]    pb [LAT];
    logic           hazard, busy, last_acc, dr_fire, dr_last, col_last;

    assign ncol_m1  = AW'(ncol_q - 1'b1);
    assign busy     = |pv;
    assign col_last = (col_cnt == ncol_m1);
    assign last_acc = acc_fire && col_last && (row_cnt == k_q - 1'b1);
    assign dr_fire  = dr_valid && dr_ready;
    assign dr_last  = (dr_col == ncol_m1) && (dr_pe_q == PEW'(NPE - 1));
    assign acc_fire = b_valid && b_ready;

    always_comb begin
        hazard = 1'b0;
        for (int i = 0; i < LAT; i++)
            if (pv[i] && (pa[i] == col_cnt)) hazard = 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (start) st_nx = (op_e'(op_in) == OP_MUL) ? S_CLEAR : S_STREAM;
            S_CLEAR:  if (clr_cnt == AW'(DEPTH - 1)) st_nx = S_STREAM;
            S_STREAM: if (k_q == '0 || last_acc) st_nx = S_FLUSH;
            S_FLUSH:  if (!busy) st_nx = S_DRAIN;
            S_DRAIN:  if (dr_fire && dr_last) st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        b_ready  = 1'b0;
        done     = 1'b0;
        dr_valid = 1'b0;
        clr_en   = 1'b0;
        ld_ok    = 1'b0;
        rd_addr  = col_cnt;
        unique case (st)
            S_IDLE:   ld_ok = 1'b1;
            S_CLEAR:  clr_en = 1'b1;
            S_STREAM: b_ready = (k_q != '0) && !hazard;
            S_FLUSH:  done = !busy;
            S_DRAIN:  begin
                dr_valid = 1'b1;
                rd_addr  = dr_col;
            end
            default:  ;
        endcase
    end

    // pass configuration and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode <= LM_X1;
            op_q     <= OP_MUL;
            k_q      <= '0;
            ncol_q   <= CW'(1);
            clr_cnt  <= '0;
            col_cnt  <= '0;
            row_cnt  <= '0;
            dr_col   <= '0;
            dr_pe_q  <= '0;
        end else begin
            if (st == S_IDLE) begin
                col_cnt <= '0;
                row_cnt <= '0;
                dr_col  <= '0;
                dr_pe_q <= '0;
                clr_cnt <= '0;
                if (start) begin
                    cfg_mode <= lane_mode_e'(mode_in);
                    op_q     <= op_e'(op_in);
                    k_q      <= k_rows;
                    ncol_q   <= n_cols;
                end
            end
            if (st == S_CLEAR) clr_cnt <= clr_cnt + 1'b1;
            if (acc_fire) begin
                if (col_last) begin
                    col_cnt <= '0;
                    row_cnt <= row_cnt + 1'b1;
                end else begin
                    col_cnt <= col_cnt + 1'b1;
                end
            end
            if (dr_fire) begin
                if (dr_col == ncol_m1) begin
                    dr_col  <= '0;
                    dr_pe_q <= dr_pe_q + 1'b1;
                end else begin
                    dr_col <= dr_col + 1'b1;
                end
            end
        end
    end

    // write-back address and B pipeline, LAT stages
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= '0;
        else        pv <= {pv[LAT-2:0], acc_fire};
    end

    always_ff @(posedge clk) begin
        pa[0] <= col_cnt;
        pb[0] <= lane_rep(cfg_mode, b_elem);
        for (int i = 1; i < LAT; i++) begin
            pa[i] <= pa[i-1];
            pb[i] <= pb[i-1];
        end
    end

    assign wb_en    = pv[LAT-1];
    assign wb_addr  = pa[LAT-1];
    assign wb_b     = pb[LAT-1];
    assign clr_addr = clr_cnt;
    assign dr_pe    = dr_pe_q;
    assign cfg_sub  = (op_q == OP_SUB);

endmodule

// File: rtl/pla_pe.sv
module pla_pe
    import pla_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int LAT   = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lane_mode_e    mode,
    input  logic          sub,
    input  logic          ld_a_en,
    input  logic          ld_c_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [63:0]   ld_data,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_addr,
    input  logic [AW-1:0] rd_addr,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [63:0]   wb_b,
    output logic [63:0]   rd_data
);

    logic [63:0] a_q;
    logic [63:0] acc_mem [DEPTH];
    logic [63:0] c_pipe  [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n)       a_q <= '0;
        else if (ld_a_en) a_q <= ld_data;
    end

    // single write port: clear, then write-back, then preload
    always_ff @(posedge clk) begin
        if (clr_en)       acc_mem[clr_addr] <= '0;
        else if (wb_en)   acc_mem[wb_addr]  <= lane_mac(mode, sub, a_q, wb_b, c_pipe[LAT-1]);
        else if (ld_c_en) acc_mem[ld_addr]  <= ld_data;
    end

    assign rd_data = acc_mem[rd_addr];

    always_ff @(posedge clk) begin
        c_pipe[0] <= rd_data;
        for (int i = 1; i < LAT; i++) c_pipe[i] <= c_pipe[i-1];
    end

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int NPE   = 4,
    parameter int DEPTH = 512,
    parameter int LAT   = 3,
    parameter int KW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PEW  = $clog2(NPE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     lane_mode,
    input  logic [1:0]     op_sel,
    input  logic [KW-1:0]  k_rows,
    input  logic [CW-1:0]  n_cols,
    input  logic           ld_valid,
    input  logic           ld_to_c,
    input  logic [PEW-1:0] ld_pe,
    input  logic [AW-1:0]  ld_addr,
    input  logic [63:0]    ld_data,
    input  logic           b_valid,
    input  logic [63:0]    b_elem,
    output logic           b_ready,
    output logic           done,
    output logic           dr_valid,
    input  logic           dr_ready,
    output logic [63:0]    dr_data
);

    logic [PEW-1:0] dr_pe;
    logic [AW-1:0]  rd_addr, clr_addr, wb_addr;
    logic           clr_en, acc_fire, wb_en, ld_ok, cfg_sub;
    logic [63:0]    wb_b;
    lane_mode_e     cfg_mode;
    logic [63:0]    pe_rd [NPE];

    pla_ctrl #(.NPE(NPE), .DEPTH(DEPTH), .LAT(LAT), .KW(KW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(lane_mode),
        .op_in(op_sel), .k_rows(k_rows), .n_cols(n_cols),
        .b_valid(b_valid), .b_elem(b_elem), .dr_ready(dr_ready),
        .b_ready(b_ready), .done(done), .dr_valid(dr_valid), .dr_pe(dr_pe),
        .rd_addr(rd_addr), .clr_en(clr_en), .clr_addr(clr_addr),
        .acc_fire(acc_fire), .wb_en(wb_en), .wb_addr(wb_addr), .wb_b(wb_b),
        .ld_ok(ld_ok), .cfg_mode(cfg_mode), .cfg_sub(cfg_sub)
    );

    for (genvar p = 0; p < NPE; p++) begin : g_pe
        logic hit;
        assign hit = ld_valid && ld_ok && (ld_pe == PEW'(p));
        pla_pe #(.DEPTH(DEPTH), .LAT(LAT)) u_pe (
            .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .sub(cfg_sub),
            .ld_a_en(hit && !ld_to_c), .ld_c_en(hit && ld_to_c),
            .ld_addr(ld_addr), .ld_data(ld_data),
            .clr_en(clr_en), .clr_addr(clr_addr), .rd_addr(rd_addr),
            .wb_en(wb_en), .wb_addr(wb_addr), .wb_b(wb_b),
            .rd_data(pe_rd[p])
        );
    end

    assign dr_data = pe_rd[dr_pe];

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        b_ready,
    input logic        done,
    input logic        dr_valid,
    input logic        dr_ready,
    input logic [63:0] dr_data
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!b_ready && !done && !dr_valid));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_then_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> dr_valid);

    assert_drain_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_data)));

    assert_no_b_in_drain_R13: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> !b_ready);

    assert_no_b_at_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !b_ready);

endmodule

bind pla_array pla_array_chk u_chk (
    .clk(clk), .rst_n(rst_n), .b_ready(b_ready), .done(done),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_data(dr_data)
);

// File: tb/pla_array_tb_top.sv
`timescale 1ns/1ps
module pla_array_tb_top;

    localparam int NPE = 2, DEPTH = 8, LAT = 3, KW = 8;
    localparam int AW = $clog2(DEPTH), CW = $clog2(DEPTH + 1), PEW = $clog2(NPE);

    logic clk = 0, rst_n = 0, start = 0;
    logic [1:0] lane_mode = 0, op_sel = 0;
    logic [KW-1:0] k_rows = 0;
    logic [CW-1:0] n_cols = 1;
    logic ld_valid = 0, ld_to_c = 0;
    logic [PEW-1:0] ld_pe = 0;
    logic [AW-1:0] ld_addr = 0;
    logic [63:0] ld_data = 0, b_elem = 0;
    logic b_valid = 0, dr_ready = 0;
    logic b_ready, done, dr_valid;
    logic [63:0] dr_data;

    int checks = 0, fails = 0, cyc = 0;
    longint unsigned a_m [NPE];
    longint unsigned c_m [NPE][DEPTH];

    always #2 clk = ~clk;

    pla_array #(.NPE(NPE), .DEPTH(DEPTH), .LAT(LAT), .KW(KW)) dut_i (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic longint unsigned rnd64();
        return {$urandom, $urandom};
    endfunction

    // reference lane step computed by shifting and masking
    function automatic longint unsigned ref_step(int md, bit sub, longint unsigned a,
                                                 longint unsigned b, longint unsigned c);
        int lanes = 1 << md;
        int w = 64 / lanes;
        longint unsigned mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
        longint unsigned bv = b & mask;
        longint unsigned r = 0;
        for (int i = 0; i < lanes; i++) begin
            longint unsigned al = (a >> (i * w)) & mask;
            longint unsigned cl = (c >> (i * w)) & mask;
            longint unsigned pr = (al * bv) & mask;
            longint unsigned v = sub ? ((cl - pr) & mask) : ((cl + pr) & mask);
            r |= v << (i * w);
        end
        return r;
    endfunction

    task automatic run_pass(string tag, int md, int op, int k, int nc, bit ident, bit stress);
        // preload A registers and every C word
        for (int p = 0; p < NPE; p++) begin
            @(negedge clk);
            a_m[p] = rnd64();
            ld_valid = 1; ld_to_c = 0; ld_pe = PEW'(p); ld_data = a_m[p];
            for (int col = 0; col < DEPTH; col++) begin
                @(negedge clk);
                ld_to_c = 1; ld_addr = AW'(col); ld_data = rnd64();
                c_m[p][col] = (op == 0) ? 64'd0 : ld_data;
            end
        end
        @(negedge clk);
        ld_valid = 0;
        start = 1; lane_mode = 2'(md); op_sel = 2'(op); k_rows = KW'(k); n_cols = CW'(nc);
        @(negedge clk);
        start = 0;
        // stream B rows
        for (int r = 0; r < k; r++) begin
            for (int col = 0; col < nc; col++) begin
                longint unsigned bv = ident ? ((rnd64() << 16) | ((r == col) ? 64'd1 : 64'd0))
                                            : rnd64();
                if (ident && md == 1) bv = (rnd64() << 32) | ((r == col) ? 64'd1 : 64'd0);
                if (ident && md == 0) bv = (r == col) ? 64'd1 : 64'd0;
                forever begin
                    logic acc;
                    b_valid = ($urandom % 5) != 0;
                    b_elem  = bv;
                    #1 acc = b_valid && b_ready;
                    @(negedge clk);
                    if (acc) break;
                end
                for (int p = 0; p < NPE; p++)
                    c_m[p][col] = ref_step(md, op == 2, a_m[p], bv, c_m[p][col]);
            end
        end
        b_valid = 0;
        // wait for the done pulse
        begin
            bit seen = 0;
            for (int t = 0; t < 50 && !seen; t++) begin
                #1;
                if (done) seen = 1;
                else @(negedge clk);
            end
            check({tag, " R10 done pulse"}, 64'(seen), 64'd1);
            check({tag, " R10 no drain at done"}, 64'(dr_valid), 64'd0);
            @(negedge clk);
            check({tag, " R10 done single, drain next"}, {62'd0, done, dr_valid}, 64'd1);
        end
        // drain and compare
        for (int p = 0; p < NPE; p++) begin
            for (int col = 0; col < nc; col++) begin
                forever begin
                    logic got;
                    dr_ready = ($urandom % 4) != 0;
                    if (stress) begin
                        ld_valid = 1; ld_to_c = $urandom % 2; ld_pe = PEW'($urandom % NPE);
                        ld_addr = AW'($urandom % DEPTH); ld_data = rnd64();
                        b_valid = 1; b_elem = rnd64();
                    end
                    #1;
                    if (stress) check({tag, " R13 b_ready low in drain"}, 64'(b_ready), 64'd0);
                    got = dr_valid && dr_ready;
                    if (got) check({tag, " R11 drain word"}, dr_data, c_m[p][col]);
                    @(negedge clk);
                    if (got) break;
                end
            end
        end
        dr_ready = 0; ld_valid = 0; b_valid = 0;
        #1 check({tag, " R11 drain ends"}, 64'(dr_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset b_ready", 64'(b_ready), 64'd0);
        check("R1 reset done/dr_valid", {62'd0, done, dr_valid}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset", {61'd0, b_ready, done, dr_valid}, 64'd0);

        run_pass("R2 R3 x1 multiply", 0, 0, 3, 4, 0, 0);
        run_pass("R2 R4 x2 multiply", 1, 0, 4, 8, 0, 0);
        run_pass("R5 R6 x4 multiply", 2, 0, 2, 5, 0, 0);
        run_pass("R7 x4 add identity", 2, 1, 6, 6, 1, 0);
        run_pass("R8 x2 sub identity", 1, 2, 4, 4, 1, 0);
        run_pass("R8 x1 sub random", 0, 2, 2, 3, 0, 0);
        run_pass("R9 single column", 2, 0, 6, 1, 0, 0);
        run_pass("R10 zero rows", 1, 1, 0, 3, 0, 0);
        run_pass("R12 R13 loads during drain", 0, 1, 2, 8, 0, 1);
        run_pass("R6 x2 full depth", 1, 0, 3, DEPTH, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule